// File: doc/BRIEF.md
# Packed Negative Multiply-Subtract Operand Router and Mask Merger

This block sits around a packed double-precision fused negative multiply-subtract datapath. It accepts one request holding three operand vectors of up to 512 bits and the instruction's control fields. It captures the request and, for every 64-bit lane, steers the two multiplicands and the subtrahend to the arithmetic lanes according to the operand form. The arithmetic lanes are outside this block. Each of them computes minus the product, minus the subtrahend, rounded once, using the rounding mode this block selects. When the lane results come back, the block merges them into the destination under the write mask and clears every lane above the active vector length.

A small control state machine sequences each request. It has four states. `ST_IDLE` waits for a request and is the only state with `req_ready` high. The `accept` transition goes from `ST_IDLE` to `ST_ISSUE` for a legal request. The `reject` transition goes from `ST_IDLE` to `ST_FAULT` for an illegal one. `ST_ISSUE` holds `op_valid` high until `res_valid` is seen, and the `result` transition then goes to `ST_DONE` while the destination register is written. `ST_DONE` raises `done` for one cycle and `ST_FAULT` raises `err` for one cycle. Both leave on the `retire` transition back to `ST_IDLE`.

Top module: `fnms_route_merge`

## Requirements
- R1: With form code 0, each active lane routes the destination lane to `op_mul_a`, the third-operand lane to `op_mul_b` and the second-operand lane to `op_sub`.
- R2: With form code 1, each active lane routes the second-operand lane to `op_mul_a`, the destination lane to `op_mul_b` and the third-operand lane to `op_sub`.
- R3: With form code 2, each active lane routes the second-operand lane to `op_mul_a`, the third-operand lane to `op_mul_b` and the destination lane to `op_sub`.
- R4: When the masked encoding (`req_masked`=1), a memory third operand (`req_mem`=1) and the broadcast flag are all set, every lane uses bits 63:0 of the third operand in place of its own slice. In every other case, including the legacy encoding, each lane uses its own slice.
- R5: The active lane count is 2, 4 or 8 for length codes 0, 1 or 2. All three operand outputs and `dst_out` are zero in every lane at or above that count.
- R6: When the masked encoding and `req_mask_en` are both set, active lane i takes its result only when mask bit i is 1. Otherwise that lane keeps the captured destination lane when `req_zero`=0 and becomes zero when `req_zero`=1. When masking is disabled, or the encoding is legacy, every active lane takes its result.
- R7: `op_rnd` equals `req_rc_embed` only for the masked encoding with a register third operand, length code 2 and the broadcast flag set. In every other case it equals `req_rc_global`.
- R8: A request is taken when `req_valid` and `req_ready` are both high. `op_valid` is high from the next cycle until the cycle in which `res_valid` is sampled. `dst_out` holds the merged value and `done` is high for exactly one cycle in the cycle after that. `req_ready` returns one cycle later.
- R9: Form code 3, length code 3, or the legacy encoding with length code 2 is illegal. Such a request raises `err` for exactly one cycle after acceptance, never raises `op_valid`, and leaves `dst_out` unchanged.
- R10: Changes on the request inputs after acceptance have no effect on the routed operands, the rounding mode or the merged destination of that request.
- R11: After reset, `dst_out` is zero, `req_ready` is 1, and `op_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_form | input | 2 | Operand form: 0, 1, 2 legal; 3 illegal |
| req_vlen | input | 2 | Vector length code: 0=128, 1=256, 2=512 bits |
| req_masked | input | 1 | 1 = masked encoding, 0 = legacy encoding |
| req_wmask | input | 8 | Per-lane write mask |
| req_mask_en | input | 1 | Write mask in use |
| req_zero | input | 1 | Zero (1) or merge (0) unwritten lanes |
| req_bcast | input | 1 | Broadcast / embedded-rounding flag |
| req_mem | input | 1 | Third operand comes from memory |
| req_rc_embed | input | 2 | Rounding mode carried by the instruction |
| req_rc_global | input | 2 | Rounding mode from the control register |
| req_dst | input | 512 | Destination (first source) vector |
| req_src2 | input | 512 | Second source vector |
| req_src3 | input | 512 | Third source vector |
| op_valid | output | 1 | Routed operands valid for the arithmetic lanes |
| op_mul_a | output | 512 | First multiplicand per lane |
| op_mul_b | output | 512 | Second multiplicand per lane |
| op_sub | output | 512 | Subtrahend per lane |
| op_rnd | output | 2 | Rounding mode for the arithmetic lanes |
| res_valid | input | 1 | Lane results valid |
| res_data | input | 512 | Per-lane rounded results |
| dst_out | output | 512 | Merged destination register |
| done | output | 1 | Merged destination updated |
| err | output | 1 | Illegal request rejected |

## Verification
Each form is driven with distinct random vectors in every lane. A routing error between the destination, the second source and the third source therefore shows up as a lane mismatch, and the lane-0 broadcast cases show whether the third operand is replicated or read per lane. The mask is exercised in several ways: random mask bytes under both merge and zero masking, an all-zero mask on the legacy encoding, and masking disabled on the masked encoding. Together these separate kept, cleared and written lanes. The three lengths show where upper clearing starts. The rounding cases vary one term of the override condition at a time (memory source, 256-bit length, legacy encoding) so that a single missing term is caught. Scrambling the inputs after acceptance and delaying the result show that the captured copy, not the live inputs, drives the outputs.

// File: rtl/fnms_pkg.sv
package fnms_pkg;

    localparam int MASK_W = 8;

    typedef enum logic [1:0] {
        FORM_132 = 2'd0,
        FORM_213 = 2'd1,
        FORM_231 = 2'd2,
        FORM_BAD = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    typedef struct packed {
        form_e             form;
        vlen_e             vlen;
        logic              masked;
        logic [MASK_W-1:0] wmask;
        logic              mask_en;
        logic              zero;
        logic              bcast;
        logic              mem;
        logic [1:0]        rc_embed;
        logic [1:0]        rc_global;
    } ctl_t;

    function automatic int lanes_of(vlen_e v);
        case (v)
            VL_128:  return 2;
            VL_256:  return 4;
            VL_512:  return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fnms_ctrl.sv
module fnms_ctrl
    import fnms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic illegal,
    input  logic res_valid,
    output logic req_ready,
    output logic capture,
    output logic op_valid,
    output logic commit,
    output logic done,
    output logic err
);

    state_e st_q;
    state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid) st_d = illegal ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: if (res_valid) st_d = ST_DONE;
            ST_FAULT: st_d = ST_IDLE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        op_valid  = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (st_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: op_valid  = 1'b1;
            ST_FAULT: err       = 1'b1;
            ST_DONE:  done      = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        capture = req_ready && req_valid;
        commit  = op_valid && res_valid;
    end

    // R8: result seen in issue leads to done next cycle
    a_r8_done_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && res_valid) |=> done);

    // R8: operands stay presented until a result arrives
    a_r8_issue_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !res_valid) |=> op_valid);

    // R8: done is a single-cycle pulse followed by ready
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R9: error is a single-cycle pulse followed by ready
    a_r9_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && req_ready));

endmodule

// File: rtl/fnms_operand_router.sv
module fnms_operand_router
    import fnms_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int NL     = 8,
    localparam int VW    = LANE_W * NL
) (
    input  form_e          form,
    input  logic           bcast_on,
    input  logic [NL-1:0]  act,
    input  logic [VW-1:0]  dst,
    input  logic [VW-1:0]  src2,
    input  logic [VW-1:0]  src3,
    output logic [VW-1:0]  mul_a,
    output logic [VW-1:0]  mul_b,
    output logic [VW-1:0]  sub
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LANE_W-1:0] d_l, s2_l, s3_l;
        logic [LANE_W-1:0] a_l, b_l, c_l;

        assign d_l  = dst[i*LANE_W +: LANE_W];
        assign s2_l = src2[i*LANE_W +: LANE_W];
        // R4: lane-0 element replicated when broadcasting
        assign s3_l = bcast_on ? src3[LANE_W-1:0] : src3[i*LANE_W +: LANE_W];

        always_comb begin
            a_l = '0;
            b_l = '0;
            c_l = '0;
            if (act[i]) begin
                case (form)
                    FORM_132: begin a_l = d_l;  b_l = s3_l; c_l = s2_l; end
                    FORM_213: begin a_l = s2_l; b_l = d_l;  c_l = s3_l; end
                    FORM_231: begin a_l = s2_l; b_l = s3_l; c_l = d_l;  end
                    default:  begin a_l = '0;   b_l = '0;   c_l = '0;   end
                endcase
            end
        end

        assign mul_a[i*LANE_W +: LANE_W] = a_l;
        assign mul_b[i*LANE_W +: LANE_W] = b_l;
        assign sub[i*LANE_W +: LANE_W]   = c_l;
    end

endmodule

// File: rtl/fnms_mask_merger.sv
module fnms_mask_merger #(
    parameter int LANE_W = 64,
    parameter int NL     = 8,
    localparam int VW    = LANE_W * NL
) (
    input  logic [NL-1:0] act,
    input  logic [NL-1:0] wr,
    input  logic          zero,
    input  logic [VW-1:0] old_dst,
    input  logic [VW-1:0] res,
    output logic [VW-1:0] merged
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LANE_W-1:0] m_l;
        always_comb begin
            if (!act[i])    m_l = '0;
            else if (wr[i]) m_l = res[i*LANE_W +: LANE_W];
            else if (zero)  m_l = '0;
            else            m_l = old_dst[i*LANE_W +: LANE_W];
        end
        assign merged[i*LANE_W +: LANE_W] = m_l;
    end

endmodule

// File: rtl/fnms_route_merge.sv
module fnms_route_merge
    import fnms_pkg::*;
#(
    parameter int MAX_VL = 512,
    parameter int LANE_W = 64,
    localparam int NL    = MAX_VL / LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_form,
    input  logic [1:0]          req_vlen,
    input  logic                req_masked,
    input  logic [MASK_W-1:0]   req_wmask,
    input  logic                req_mask_en,
    input  logic                req_zero,
    input  logic                req_bcast,
    input  logic                req_mem,
    input  logic [1:0]          req_rc_embed,
    input  logic [1:0]          req_rc_global,
    input  logic [MAX_VL-1:0]   req_dst,
    input  logic [MAX_VL-1:0]   req_src2,
    input  logic [MAX_VL-1:0]   req_src3,
    output logic                op_valid,
    output logic [MAX_VL-1:0]   op_mul_a,
    output logic [MAX_VL-1:0]   op_mul_b,
    output logic [MAX_VL-1:0]   op_sub,
    output logic [1:0]          op_rnd,
    input  logic                res_valid,
    input  logic [MAX_VL-1:0]   res_data,
    output logic [MAX_VL-1:0]   dst_out,
    output logic                done,
    output logic                err
);

    ctl_t              ctl_q;
    logic [MAX_VL-1:0] dst_q, src2_q, src3_q, out_q;
    logic [MAX_VL-1:0] merged;
    logic [MAX_VL-1:0] upper_bits;
    logic [NL-1:0]     act, wr;
    logic              capture, commit, illegal;
    logic              mask_on, bcast_on, embed_ov;

    // R9: illegal form, length, or legacy at full width
    assign illegal = (req_form == 2'd3) || (req_vlen == 2'd3)
                   || (!req_masked && req_vlen == 2'd2);

    fnms_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .illegal   (illegal),
        .res_valid (res_valid),
        .req_ready (req_ready),
        .capture   (capture),
        .op_valid  (op_valid),
        .commit    (commit),
        .done      (done),
        .err       (err)
    );

    // R10: request captured once, on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            dst_q  <= '0;
            src2_q <= '0;
            src3_q <= '0;
        end else if (capture) begin
            ctl_q.form      <= form_e'(req_form);
            ctl_q.vlen      <= vlen_e'(req_vlen);
            ctl_q.masked    <= req_masked;
            ctl_q.wmask     <= req_wmask;
            ctl_q.mask_en   <= req_mask_en;
            ctl_q.zero      <= req_zero;
            ctl_q.bcast     <= req_bcast;
            ctl_q.mem       <= req_mem;
            ctl_q.rc_embed  <= req_rc_embed;
            ctl_q.rc_global <= req_rc_global;
            dst_q           <= req_dst;
            src2_q          <= req_src2;
            src3_q          <= req_src3;
        end
    end

    assign mask_on  = ctl_q.masked && ctl_q.mask_en;
    assign bcast_on = ctl_q.masked && ctl_q.mem && ctl_q.bcast;
    // R7: embedded rounding only for masked, register, full width, flag set
    assign embed_ov = ctl_q.masked && !ctl_q.mem && ctl_q.bcast && (ctl_q.vlen == VL_512);
    assign op_rnd   = embed_ov ? ctl_q.rc_embed : ctl_q.rc_global;

    for (genvar i = 0; i < NL; i++) begin : g_lane_ctl
        assign act[i] = (i < lanes_of(ctl_q.vlen));
        if (i < MASK_W) begin : g_m
            assign wr[i] = !mask_on || ctl_q.wmask[i];
        end else begin : g_nm
            assign wr[i] = !mask_on;
        end
        assign upper_bits[i*LANE_W +: LANE_W] = {LANE_W{!act[i]}};
    end

    fnms_operand_router #(.LANE_W(LANE_W), .NL(NL)) u_router (
        .form     (ctl_q.form),
        .bcast_on (bcast_on),
        .act      (act),
        .dst      (dst_q),
        .src2     (src2_q),
        .src3     (src3_q),
        .mul_a    (op_mul_a),
        .mul_b    (op_mul_b),
        .sub      (op_sub)
    );

    fnms_mask_merger #(.LANE_W(LANE_W), .NL(NL)) u_merger (
        .act     (act),
        .wr      (wr),
        .zero    (ctl_q.zero),
        .old_dst (dst_q),
        .res     (res_data),
        .merged  (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= '0;
        else if (commit) out_q <= merged;
    end

    assign dst_out = out_q;

    // R9: rejected request leaves destination unchanged
    a_r9_keep_dst: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(dst_out));

    // R9: no issue to the arithmetic lanes alongside an error
    a_r9_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !op_valid);

    // R5: lanes beyond the active length are clear when done
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((dst_out & upper_bits) == '0));

    // R7: rounding mode steady while operands are presented
    a_r7_rnd_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(op_valid)) |-> $stable(op_rnd));

    // R10: routed operands steady while presented
    a_r10_ops_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(op_valid)) |-> ($stable(op_mul_a) && $stable(op_mul_b) && $stable(op_sub)));

endmodule

// File: tb/tb_fnms_route_merge.sv
module tb_fnms_route_merge;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_form = '0, req_vlen = '0;
    logic         req_masked = 1'b0;
    logic [7:0]   req_wmask = '0;
    logic         req_mask_en = 1'b0, req_zero = 1'b0, req_bcast = 1'b0, req_mem = 1'b0;
    logic [1:0]   req_rc_embed = '0, req_rc_global = '0;
    logic [511:0] req_dst = '0, req_src2 = '0, req_src3 = '0;
    logic         op_valid;
    logic [511:0] op_mul_a, op_mul_b, op_sub;
    logic [1:0]   op_rnd;
    logic         res_valid = 1'b0;
    logic [511:0] res_data = '0;
    logic [511:0] dst_out;
    logic         done, err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fnms_route_merge dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_form(req_form), .req_vlen(req_vlen), .req_masked(req_masked),
        .req_wmask(req_wmask), .req_mask_en(req_mask_en), .req_zero(req_zero),
        .req_bcast(req_bcast), .req_mem(req_mem), .req_rc_embed(req_rc_embed),
        .req_rc_global(req_rc_global), .req_dst(req_dst), .req_src2(req_src2),
        .req_src3(req_src3), .op_valid(op_valid), .op_mul_a(op_mul_a),
        .op_mul_b(op_mul_b), .op_sub(op_sub), .op_rnd(op_rnd),
        .res_valid(res_valid), .res_data(res_data), .dst_out(dst_out),
        .done(done), .err(err)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // which: 0 = first multiplicand, 1 = second multiplicand, 2 = subtrahend
    function automatic logic [511:0] exp_route(int which, logic [1:0] f, logic [1:0] v,
            logic m, logic b, logic mem, logic [511:0] d, logic [511:0] s2, logic [511:0] s3);
        logic [511:0] r = '0;
        logic [63:0]  dl, s2l, s3l, x;
        int nl = 2 << v;
        for (int i = 0; i < 8; i++) begin
            dl  = d[i*64 +: 64];
            s2l = s2[i*64 +: 64];
            s3l = (m && mem && b) ? s3[63:0] : s3[i*64 +: 64];
            if (f == 2'd0)      x = (which == 0) ? dl  : (which == 1) ? s3l : s2l;
            else if (f == 2'd1) x = (which == 0) ? s2l : (which == 1) ? dl  : s3l;
            else                x = (which == 0) ? s2l : (which == 1) ? s3l : dl;
            if (i < nl) r[i*64 +: 64] = x;
        end
        return r;
    endfunction

    function automatic logic [511:0] exp_merge(logic [1:0] v, logic m, logic [7:0] wm,
            logic me, logic z, logic [511:0] d, logic [511:0] r);
        logic [511:0] o = '0;
        int nl = 2 << v;
        for (int i = 0; i < 8; i++) begin
            if (i < nl) begin
                if (!(m && me) || wm[i]) o[i*64 +: 64] = r[i*64 +: 64];
                else if (z)              o[i*64 +: 64] = '0;
                else                     o[i*64 +: 64] = d[i*64 +: 64];
            end
        end
        return o;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_op(input logic [1:0] f, input logic [1:0] v, input logic m,
            input logic [7:0] wm, input logic me, input logic z, input logic b,
            input logic mem, input logic [1:0] re, input logic [1:0] rg, input int dly);
        logic [511:0] d, s2, s3, r, prev, e;
        logic [1:0]   erd;
        bit           bad;
        string        ftag;
        d = rnd512(); s2 = rnd512(); s3 = rnd512(); r = rnd512();
        bad = (f == 2'd3) || (v == 2'd3) || (!m && v == 2'd2);
        ftag = (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : "R3";
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready in idle", {511'd0, req_ready}, 512'd1);
        prev = dst_out;
        req_form = f; req_vlen = v; req_masked = m; req_wmask = wm; req_mask_en = me;
        req_zero = z; req_bcast = b; req_mem = mem; req_rc_embed = re; req_rc_global = rg;
        req_dst = d; req_src2 = s2; req_src3 = s3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: scramble inputs after acceptance
        req_dst = rnd512(); req_src2 = rnd512(); req_src3 = rnd512();
        req_form = 2'($urandom); req_vlen = 2'($urandom); req_wmask = 8'($urandom);
        req_masked = 1'($urandom); req_bcast = 1'($urandom); req_mem = 1'($urandom);
        req_rc_embed = 2'($urandom); req_rc_global = 2'($urandom); req_zero = 1'($urandom);
        if (bad) begin
            chk(err == 1'b1, "R9 err raised", {511'd0, err}, 512'd1);
            chk(op_valid == 1'b0, "R9 no issue", {511'd0, op_valid}, 512'd0);
            chk(dst_out == prev, "R9 dst kept", dst_out, prev);
            @(negedge clk);
            chk(err == 1'b0 && req_ready == 1'b1, "R9 err single cycle", {510'd0, err, req_ready}, 512'd1);
            return;
        end
        chk(op_valid == 1'b1, "R8 op_valid after accept", {511'd0, op_valid}, 512'd1);
        e = exp_route(0, f, v, m, b, mem, d, s2, s3);
        chk(op_mul_a == e, {ftag, " R4 R5 R10 mul_a"}, op_mul_a, e);
        e = exp_route(1, f, v, m, b, mem, d, s2, s3);
        chk(op_mul_b == e, {ftag, " R4 R5 R10 mul_b"}, op_mul_b, e);
        e = exp_route(2, f, v, m, b, mem, d, s2, s3);
        chk(op_sub == e, {ftag, " R4 R5 R10 sub"}, op_sub, e);
        erd = (m && !mem && v == 2'd2 && b) ? re : rg;
        chk(op_rnd == erd, "R7 rounding mode", {510'd0, op_rnd}, {510'd0, erd});
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(op_valid == 1'b1 && done == 1'b0 && dst_out == prev, "R8 wait for result",
                dst_out, prev);
        end
        res_valid = 1'b1; res_data = r;
        @(negedge clk);
        res_valid = 1'b0; res_data = rnd512();
        chk(done == 1'b1 && op_valid == 1'b0, "R8 done after result", {510'd0, done, op_valid}, 512'd2);
        e = exp_merge(v, m, wm, me, z, d, r);
        chk(dst_out == e, "R6 R5 merged dst", dst_out, e);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R8 done single cycle", {510'd0, done, req_ready}, 512'd1);
        chk(dst_out == e, "R6 dst holds", dst_out, e);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(dst_out == '0, "R11 dst zero", dst_out, '0);
        chk(req_ready == 1'b1 && op_valid == 1'b0 && done == 1'b0 && err == 1'b0,
            "R11 control idle", {508'd0, req_ready, op_valid, done, err}, 512'd8);
        rst_n = 1'b1;
        // directed: each form at each length, masked, mask off
        for (int f = 0; f < 3; f++)
            for (int v = 0; v < 3; v++)
                do_op(2'(f), 2'(v), 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2, 0);
        // R6 merge and zero masking
        do_op(2'd0, 2'd2, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1);
        do_op(2'd1, 2'd2, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 2);
        do_op(2'd2, 2'd1, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 0);
        // R6 legacy ignores the mask
        do_op(2'd2, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 0);
        // R4 broadcast from memory, and legacy ignoring broadcast
        do_op(2'd0, 2'd2, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 2'd0, 0);
        do_op(2'd2, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 2'd0, 0);
        // R7 override and each missing term
        do_op(2'd1, 2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 0);
        do_op(2'd1, 2'd1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 0);
        do_op(2'd1, 2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 0);
        do_op(2'd1, 2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 0);
        // R9 illegal combinations
        do_op(2'd3, 2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 0);
        do_op(2'd0, 2'd3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 0);
        do_op(2'd0, 2'd2, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 0);
        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [1:0] f, v;
            f = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
            v = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
            do_op(f, v, 1'($urandom % 4 != 0), 8'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), int'($urandom % 4));
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule